// File: doc/BRIEF.md
# Programmable Clock Phase Sequencer

This block turns a free-running oscillator clock into the timing frame that a core and its peripherals run on. A prescaler stretches every step of the frame to 1, 2, 4, ... 128 oscillator cycles, under a 3-bit divide code that software may rewrite at any time. The stretched steps are called slots. Two slots make a state: the first is phase P1 and the second is phase P2. Six states make one peripheral cycle, which is twelve slots long.

The divide code takes effect only where one peripheral cycle ends and the next begins, so no slot in flight ever changes length. The core advances on `core_ce`, a clock enable that pulses in the first oscillator cycle of every slot. Peripherals pick their moment from a one-hot slot strobe vector or from the cycle-start pulse. All outputs come from registers and do not depend on `div_code` through logic alone. The block has no data stream, so every pin is a plain control or status level.

Top module: `phase_seq_top`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) puts the block in state 1, phase P1, at the first oscillator cycle of a slot, with a divide ratio of 1. The first peripheral cycle after reset is 12 oscillator cycles long, whatever `div_code` holds.
- R2: Each slot lasts exactly 2^r oscillator cycles, where r is the active divide code. `core_ce` is high in the first cycle of every slot and low in all its other cycles.
- R3: `phase` is 0 for P1 and 1 for P2. Within each state the phase goes P1 then P2. `state_idx` stays constant over both phases, steps up by one after P2, and wraps from 6 back to 1. Neither output changes except when a new slot starts.
- R4: A peripheral cycle is twelve slots, which is 12 * 2^r oscillator cycles at a constant active code r.
- R5: `slot_strobe[k]`, with k = 2*(state_idx-1) + phase, is high only in the first oscillator cycle of slot k. At most one bit is ever high.
- R6: `cycle_start` is high exactly when `slot_strobe[0]` is high, which is the first cycle of state 1, phase P1.
- R7: Divide code n (0 to 7) selects a ratio of 2^n: codes 0, 1, 3 and 7 give peripheral cycles of 12, 24, 96 and 1536 oscillator cycles.
- R8: `div_code` is sampled only in the last oscillator cycle of state 6, phase P2, and applies from the following `cycle_start` onward. A change in the middle of a cycle leaves that cycle's length unchanged.
- R9: A change of `div_code` that is undone before the sampling cycle has no effect on any later cycle length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| div_code | input | 3 | Requested divide code, ratio 2^code |
| core_ce | output | 1 | Core clock enable, first cycle of each slot |
| state_idx | output | 3 | Current state, 1 to 6 |
| phase | output | 1 | 0 = P1, 1 = P2 |
| slot_strobe | output | 12 | One-hot slot strobe, bit 2*(state-1)+phase |
| cycle_start | output | 1 | Peripheral cycle start pulse |

## Verification
The bound checker verifies the local rules on every cycle. It checks that the strobe vector is one-hot or zero, that the cycle-start pulse agrees with strobe bit 0 and with state 1 P1, that the state and phase hold still between enables and step in order, and that the gap between enables matches the ratio in force. It also checks that the active ratio changes only at a cycle start. The bench's scenarios are needed to show the effects that depend on when `div_code` is sampled. These are the delay of a new code by one whole peripheral cycle, the lack of any effect from a code that is changed and then restored, the full cycle lengths for several codes, and the return to a ratio of 1 after a reset in the middle of a run.

// File: rtl/pseq_pkg.sv
package pseq_pkg;
  // Two phases per state is fixed by the frame definition.
  localparam int PHASES = 2;

  // Largest prescaler terminal count for a given code width.
  function automatic int max_limit(input int code_w);
    return (1 << ((1 << code_w) - 1)) - 1;
  endfunction

  // Number of bits to hold the prescaler count.
  function automatic int cnt_width(input int code_w);
    return (1 << code_w) - 1;
  endfunction
endpackage

// File: rtl/pseq_prescaler.sv
module pseq_prescaler #(
  parameter int CODE_W = 3,
  localparam int CNT_W = pseq_pkg::cnt_width(CODE_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] code_in,
  input  logic              frame_last,
  output logic              core_ce,
  output logic              period_end,
  output logic [CODE_W-1:0] active_code
);
  logic [CNT_W-1:0]  cnt_q;
  logic [CODE_W-1:0] code_q;
  logic [CNT_W-1:0]  limit;

  // Terminal count for the ratio in force: 2^code - 1.
  always_comb begin
    limit = '0;
    for (int b = 0; b < CNT_W; b++) begin
      if (b < int'(code_q)) limit[b] = 1'b1;
    end
  end

  assign period_end  = (cnt_q == limit);
  assign core_ce     = (cnt_q == '0);
  assign active_code = code_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (period_end) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  // The ratio is reloaded only as the last slot of a frame closes.
  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= '0;
    end else if (period_end && frame_last) begin
      code_q <= code_in;
    end
  end
endmodule

// File: rtl/pseq_slot_ctr.sv
module pseq_slot_ctr #(
  parameter int SLOTS = 12,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              advance,
  output logic [SLOT_W-1:0] slot,
  output logic              frame_last
);
  logic [SLOT_W-1:0] slot_q;

  assign slot       = slot_q;
  assign frame_last = (slot_q == SLOT_W'(SLOTS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q <= '0;
    end else if (advance) begin
      slot_q <= frame_last ? '0 : slot_q + SLOT_W'(1);
    end
  end
endmodule

// File: rtl/pseq_slot_decode.sv
module pseq_slot_decode #(
  parameter int NUM_STATES = 6,
  localparam int SLOTS   = NUM_STATES * pseq_pkg::PHASES,
  localparam int SLOT_W  = $clog2(SLOTS),
  localparam int STATE_W = $clog2(NUM_STATES + 1)
) (
  input  logic [SLOT_W-1:0]  slot,
  input  logic               core_ce,
  output logic [STATE_W-1:0] state_idx,
  output logic               phase,
  output logic [SLOTS-1:0]   slot_strobe,
  output logic               cycle_start
);
  logic [SLOT_W-1:0] pair;

  assign pair      = slot >> 1;
  assign state_idx = STATE_W'(pair) + STATE_W'(1);
  assign phase     = slot[0];

  for (genvar k = 0; k < SLOTS; k++) begin : g_strobe
    assign slot_strobe[k] = core_ce && (slot == SLOT_W'(k));
  end

  assign cycle_start = core_ce && (pair == '0) && !slot[0];
endmodule

// File: rtl/phase_seq_top.sv
module phase_seq_top #(
  parameter int CODE_W     = 3,
  parameter int NUM_STATES = 6,
  localparam int SLOTS   = NUM_STATES * pseq_pkg::PHASES,
  localparam int SLOT_W  = $clog2(SLOTS),
  localparam int STATE_W = $clog2(NUM_STATES + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [CODE_W-1:0]  div_code,
  output logic               core_ce,
  output logic [STATE_W-1:0] state_idx,
  output logic               phase,
  output logic [SLOTS-1:0]   slot_strobe,
  output logic               cycle_start
);
  logic              period_end;
  logic              frame_last;
  logic [SLOT_W-1:0] slot;
  logic [CODE_W-1:0] act_code;

  pseq_prescaler #(.CODE_W(CODE_W)) u_pre (
    .clk        (clk),
    .rst        (rst),
    .code_in    (div_code),
    .frame_last (frame_last),
    .core_ce    (core_ce),
    .period_end (period_end),
    .active_code(act_code)
  );

  pseq_slot_ctr #(.SLOTS(SLOTS)) u_slot (
    .clk       (clk),
    .rst       (rst),
    .advance   (period_end),
    .slot      (slot),
    .frame_last(frame_last)
  );

  pseq_slot_decode #(.NUM_STATES(NUM_STATES)) u_dec (
    .slot       (slot),
    .core_ce    (core_ce),
    .state_idx  (state_idx),
    .phase      (phase),
    .slot_strobe(slot_strobe),
    .cycle_start(cycle_start)
  );
endmodule

// File: rtl/pseq_checker.sv
module pseq_checker #(
  parameter int CODE_W     = 3,
  parameter int NUM_STATES = 6,
  localparam int SLOTS   = NUM_STATES * pseq_pkg::PHASES,
  localparam int STATE_W = $clog2(NUM_STATES + 1),
  localparam int GAP_W   = pseq_pkg::cnt_width(CODE_W) + 1
) (
  input logic               clk,
  input logic               rst,
  input logic               core_ce,
  input logic [STATE_W-1:0] state_idx,
  input logic               phase,
  input logic [SLOTS-1:0]   slot_strobe,
  input logic               cycle_start,
  input logic [CODE_W-1:0]  act
);
  logic [GAP_W-1:0] gap;
  logic             seen;

  // Cycles since the last enable, for the slot-length window.
  always_ff @(posedge clk) begin
    if (rst) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (core_ce) begin
      gap  <= '0;
      seen <= 1'b1;
    end else begin
      gap <= gap + GAP_W'(1);
    end
  end

  assert_onehot_strobe_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(slot_strobe));

  assert_strobe_needs_ce_R5: assert property (@(posedge clk) disable iff (rst)
    (slot_strobe != '0) |-> core_ce);

  assert_start_is_s1p1_R6: assert property (@(posedge clk) disable iff (rst)
    cycle_start |-> (core_ce && state_idx == STATE_W'(1) && !phase && slot_strobe[0]));

  assert_strobe0_gives_start_R6: assert property (@(posedge clk) disable iff (rst)
    slot_strobe[0] |-> cycle_start);

  assert_hold_between_ce_R3: assert property (@(posedge clk) disable iff (rst)
    !core_ce |-> ($stable(state_idx) && $stable(phase)));

  assert_p2_same_state_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(phase) |-> $stable(state_idx));

  assert_state_steps_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(phase) |-> (state_idx == (($past(state_idx) == STATE_W'(NUM_STATES))
                                     ? STATE_W'(1) : $past(state_idx) + STATE_W'(1))));

  assert_state_range_R3: assert property (@(posedge clk) disable iff (rst)
    (state_idx >= STATE_W'(1)) && (state_idx <= STATE_W'(NUM_STATES)));

  assert_slot_length_R2: assert property (@(posedge clk) disable iff (rst)
    (core_ce && seen) |-> (gap == GAP_W'((1 << $past(act)) - 1)));

  assert_ratio_at_boundary_R8: assert property (@(posedge clk) disable iff (rst)
    !$stable(act) |-> cycle_start);
endmodule

bind phase_seq_top pseq_checker #(.CODE_W(CODE_W), .NUM_STATES(NUM_STATES)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .core_ce    (core_ce),
  .state_idx  (state_idx),
  .phase      (phase),
  .slot_strobe(slot_strobe),
  .cycle_start(cycle_start),
  .act        (act_code)
);

// File: tb/sim_phase_seq_top.sv
module sim_phase_seq_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  div_code = 3'd0;
  logic        core_ce;
  logic [2:0]  state_idx;
  logic        phase;
  logic [11:0] slot_strobe;
  logic        cycle_start;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  phase_seq_top u0 (
    .clk(clk), .rst(rst), .div_code(div_code), .core_ce(core_ce),
    .state_idx(state_idx), .phase(phase), .slot_strobe(slot_strobe),
    .cycle_start(cycle_start)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: slot position, cycles within slot, ratio in force.
  int  m_slot = 0, m_cnt = 0, m_ratio = 0;
  bit  started = 0;

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      m_slot = 0; m_cnt = 0; m_ratio = 0;
    end else if (m_cnt == (1 << m_ratio) - 1) begin
      m_cnt = 0;
      if (m_slot == 11) begin
        m_slot = 0;
        m_ratio = int'(div_code);
      end else begin
        m_slot++;
      end
    end else begin
      m_cnt++;
    end
  end

  // Every-cycle comparison against the reference.
  always @(negedge clk) begin
    if (started && !rst) begin
      int exp_state, exp_phase, exp_ce, exp_strobe, exp_start;
      exp_state  = m_slot / 2 + 1;
      exp_phase  = m_slot % 2;
      exp_ce     = (m_cnt == 0) ? 1 : 0;
      exp_strobe = exp_ce ? (1 << m_slot) : 0;
      exp_start  = (exp_ce == 1 && m_slot == 0) ? 1 : 0;
      chk(int'(state_idx) == exp_state, "R3 state_idx", int'(state_idx), exp_state);
      chk(int'(phase) == exp_phase, "R3 phase", int'(phase), exp_phase);
      chk(int'(core_ce) == exp_ce, "R2 core_ce", int'(core_ce), exp_ce);
      chk(int'(slot_strobe) == exp_strobe, "R5 slot_strobe", int'(slot_strobe), exp_strobe);
      chk(int'(cycle_start) == exp_start, "R6 cycle_start", int'(cycle_start), exp_start);
    end
  end

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      chk(1'b0, "R4 watchdog", cycles, 150000);
      summary();
      $finish;
    end
  end

  // Called at a negedge where cycle_start is high; counts clocks to the next
  // start, optionally rewriting div_code at two offsets on the way.
  task automatic run_cycle(input int exp_len, input string req,
                           input int ca, input int code_a,
                           input int cb, input int code_b);
    int n = 0;
    do begin
      if (n == ca) div_code = 3'(code_a);
      if (n == cb) div_code = 3'(code_b);
      @(negedge clk);
      n++;
    end while (!cycle_start);
    chk(n == exp_len, req, n, exp_len);
  endtask

  task automatic check_reset_state();
    chk(state_idx == 3'd1, "R1 state after reset", int'(state_idx), 1);
    chk(phase == 1'b0, "R1 phase after reset", int'(phase), 0);
    chk(core_ce == 1'b1, "R1 core_ce after reset", int'(core_ce), 1);
    chk(cycle_start == 1'b1, "R1 cycle_start after reset", int'(cycle_start), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check_reset_state();
    // R1 ratio 1 first; R8 code written mid-cycle does not stretch it.
    run_cycle(12, "R8 mid-cycle write keeps 12", 5, 1, -1, 0);
    run_cycle(24, "R7 code 1 gives 24", 0, 3, -1, 0);
    run_cycle(96, "R8 code 3 gives 96 despite write", 40, 7, -1, 0);
    run_cycle(1536, "R7 code 7 gives 1536", 1, 0, -1, 0);
    run_cycle(12, "R4 code 0 gives 12", -1, 0, -1, 0);
    // R9: change and restore before the sampling cycle.
    run_cycle(12, "R9 pulse cycle length", 2, 5, 7, 0);
    run_cycle(12, "R9 restored code ignored", 0, 2, -1, 0);
    run_cycle(48, "R7 code 2 gives 48", 0, 3, -1, 0);
    // R1: reset in the middle of a ratio-8 cycle.
    repeat (30) @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check_reset_state();
    run_cycle(12, "R1 ratio back to 1 after reset", -1, 0, -1, 0);
    run_cycle(96, "R8 code 3 loaded at boundary", -1, 0, -1, 0);
    summary();
    $finish;
  end
endmodule